// File: doc/BRIEF.md
# DDR Bank Activation Timing Checker

This block watches the command stream sent to a four-bank DDR SDRAM device, one command per clock. For each cycle it decides at once whether the presented command is allowed and reports the result on `cmd_ok`. It also sets a sticky flag for every timing or state rule that the command breaks. Per bank, it keeps an open-row flag and the row address that the last accepted ACTIVE selected. Both are visible at the ports, so the checker can sit beside a memory controller as a protocol monitor.

Timing limits are given as real-valued nanosecond parameters, along with the clock period. At elaboration each limit is turned into a whole number of clocks by rounding the ratio upward. Three spacing rules are enforced:

- ACTIVE to READ or WRITE in the same bank.
- ACTIVE to ACTIVE in the same bank.
- ACTIVE to ACTIVE across different banks.

A row may be opened in a second bank while the first bank is still open. A rejected command leaves every bank's state and every counter untouched.

Top module: `ddr_act_checker`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), all banks are closed, all five error flags are 0, and an ACTIVE to any bank is accepted in the first cycle after reset.
- R2: A READ (cmd 2) or WRITE (cmd 3) to a bank without an open row gives `cmd_ok`=0 in that cycle and sets `err_no_row` at the next edge.
- R3: A READ or WRITE to an open bank k cycles after the accepted ACTIVE to that bank is legal only when k >= ceil(tRCD/tCK), which is 3 by default; an earlier one gives `cmd_ok`=0 and sets `err_rcd`.
- R4: An ACTIVE (cmd 1) to a bank that already has an open row is rejected and sets `err_row_open`.
- R5: An ACTIVE to a bank k cycles after the previous accepted ACTIVE to that bank is rejected and sets `err_rc` when k < ceil(tRC/tCK), which is 9 by default. This holds even if the bank was precharged in between.
- R6: An ACTIVE to a bank other than the last activated one is rejected and sets `err_rrd` when it comes fewer than ceil(tRRD/tCK) cycles (2 by default) after that last accepted ACTIVE. An accepted ACTIVE leaves other banks' rows open.
- R7: PRECHARGE (cmd 4) is always legal and closes the addressed bank. It has no effect on a bank that is already closed.
- R8: A rejected command changes no bank's open flag or stored row, and it restarts no timer.
- R9: An accepted ACTIVE sets `bank_open[b]` and stores the 13-bit row in `open_rows[b*13 +: 13]` from the next cycle.
- R10: Limits convert by ceiling, so an exact ratio maps to itself: tRRD = 15 ns at 7.5 ns gives exactly 2 cycles, and an ACTIVE to another bank 2 cycles later is legal.
- R11: Error flags are sticky until reset. NOP (0) and the unused codes 5 to 7 are always legal and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5-7 treated as NOP |
| bank | input | 2 | Bank address of the command |
| row | input | 13 | Row address used by ACTIVE |
| cmd_ok | output | 1 | Current command is legal (combinational) |
| err_no_row | output | 1 | Sticky: READ/WRITE to a closed bank |
| err_row_open | output | 1 | Sticky: ACTIVE to an already open bank |
| err_rcd | output | 1 | Sticky: READ/WRITE too soon after ACTIVE |
| err_rc | output | 1 | Sticky: same-bank ACTIVE spacing broken |
| err_rrd | output | 1 | Sticky: cross-bank ACTIVE spacing broken |
| bank_open | output | 4 | Per-bank open-row flag |
| open_rows | output | 52 | Stored row per bank, bank b at bits b*13 +: 13 |

## Verification
The assertions check on every cycle the following properties:

- Flags never clear without reset.
- A rejected command leaves the open vector unchanged.
- An accepted READ or WRITE always targets an open bank.
- A bank only opens after an accepted ACTIVE and closes after a PRECHARGE.
- The same-bank delay and cross-bank spacing block commands in the cycle right after an ACTIVE.

Only the bench's scenarios can show that the exact boundary cycles come out of the ceiling conversion. This covers tRCD at 3 cycles, tRC at 9 cycles even across a precharge, and the exact tRRD value of 2. The scenarios also show that the stored row survives a rejected re-activation.

// File: rtl/ddr_act_pkg.sv
package ddr_act_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // Smallest whole clock count n with n * tck >= limit (ceiling of the ratio).
  function automatic int ns_to_clk(real lim_ns, real tck_ns);
    int n;
    n = 0;
    while ((n < 65536) && ($itor(n) * tck_ns < lim_ns)) n++;
    return n;
  endfunction

  // Counter width able to hold values 0..c.
  function automatic int cnt_bits(int c);
    return (c < 2) ? 1 : $clog2(c + 1);
  endfunction

  // Value loaded on ACTIVE so that the counter reads zero exactly c cycles later.
  function automatic int load_val(int c);
    return (c > 0) ? c - 1 : 0;
  endfunction

endpackage

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
  import ddr_act_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int RCD_CYC = 3,
  parameter int RC_CYC  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_take,
  input  logic             pre_take,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rcd_done,
  output logic             rc_done
);
  localparam int RCD_W = cnt_bits(RCD_CYC);
  localparam int RC_W  = cnt_bits(RC_CYC);
  localparam logic [RCD_W-1:0] RCD_LD = RCD_W'(load_val(RCD_CYC));
  localparam logic [RC_W-1:0]  RC_LD  = RC_W'(load_val(RC_CYC));

  logic [RCD_W-1:0] rcd_cnt;
  logic [RC_W-1:0]  rc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open  <= 1'b0;
      open_row <= '0;
      rcd_cnt  <= '0;
      rc_cnt   <= '0;
    end else begin
      if (act_take) begin
        is_open  <= 1'b1;
        open_row <= row_in;
        rcd_cnt  <= RCD_LD;
        rc_cnt   <= RC_LD;
      end else begin
        if (pre_take)      is_open <= 1'b0;
        if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
        if (rc_cnt != '0)  rc_cnt  <= rc_cnt - 1'b1;
      end
    end
  end

  assign rcd_done = (rcd_cnt == '0);
  assign rc_done  = (rc_cnt == '0);

  // R9: a bank only becomes open through an accepted ACTIVE
  p_open_from_act_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(is_open) |-> $past(act_take));
  // R7: precharge closes the bank on the next cycle
  p_pre_closes_r7: assert property (@(posedge clk) disable iff (rst)
    pre_take |=> !is_open);
  // R3: access delay is pending right after an ACTIVE
  p_rcd_pending_r3: assert property (@(posedge clk) disable iff (rst)
    (act_take && (RCD_CYC > 1)) |=> !rcd_done);
  // R5: same-bank spacing is pending right after an ACTIVE
  p_rc_pending_r5: assert property (@(posedge clk) disable iff (rst)
    (act_take && (RC_CYC > 1)) |=> !rc_done);

endmodule

// File: rtl/ddr_rrd_gate.sv
module ddr_rrd_gate
  import ddr_act_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int RRD_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act_take,
  input  logic [BA_W-1:0] cur_bank,
  output logic            rrd_clear
);
  localparam int CW = cnt_bits(RRD_CYC);
  localparam logic [CW-1:0] RRD_LD = CW'(load_val(RRD_CYC));

  logic [CW-1:0]   cnt;
  logic [BA_W-1:0] last_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      last_bank <= '0;
    end else if (act_take) begin
      cnt       <= RRD_LD;
      last_bank <= cur_bank;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Same bank is governed by the row-cycle rule, not this one.
  assign rrd_clear = (cnt == '0) || (cur_bank == last_bank);

  // R6: a different bank is blocked in the cycle right after an ACTIVE
  p_rrd_block_r6: assert property (@(posedge clk) disable iff (rst)
    (act_take && (RRD_CYC > 1)) |=> ((cur_bank == $past(cur_bank)) || !rrd_clear));

endmodule

// File: rtl/ddr_cmd_judge.sv
module ddr_cmd_judge
  import ddr_act_pkg::*;
(
  input  logic [2:0] cmd,
  input  logic       sel_open,
  input  logic       sel_rcd_done,
  input  logic       sel_rc_done,
  input  logic       rrd_clear,
  output logic [4:0] viol,
  output logic       legal,
  output logic       act_take,
  output logic       pre_take
);
  logic is_act, is_rw, is_pre;

  always_comb begin
    is_act = (cmd == CMD_ACT);
    is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
    is_pre = (cmd == CMD_PRE);
    // order: no_row, row_open, rcd, rc, rrd
    viol[0] = is_rw && !sel_open;
    viol[1] = is_act && sel_open;
    viol[2] = is_rw && sel_open && !sel_rcd_done;
    viol[3] = is_act && !sel_rc_done;
    viol[4] = is_act && !rrd_clear;
    legal    = (viol == 5'b0);
    act_take = is_act && legal;
    pre_take = is_pre;
  end

endmodule

// File: rtl/ddr_act_checker.sv
module ddr_act_checker
  import ddr_act_pkg::*;
#(
  parameter real TCK_NS    = 7.5,
  parameter real TRCD_NS   = 20.0,
  parameter real TRC_NS    = 65.0,
  parameter real TRRD_NS   = 15.0,
  parameter int  NUM_BANKS = 4,
  parameter int  ROW_W     = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] bank,
  input  logic [ROW_W-1:0]           row,
  output logic                       cmd_ok,
  output logic                       err_no_row,
  output logic                       err_row_open,
  output logic                       err_rcd,
  output logic                       err_rc,
  output logic                       err_rrd,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows
);
  localparam int BA_W    = $clog2(NUM_BANKS);
  localparam int RCD_CYC = ns_to_clk(TRCD_NS, TCK_NS);
  localparam int RC_CYC  = ns_to_clk(TRC_NS, TCK_NS);
  localparam int RRD_CYC = ns_to_clk(TRRD_NS, TCK_NS);

  logic [NUM_BANKS-1:0] rcd_done_v, rc_done_v, act_v, pre_v;
  logic [4:0] viol, err_q;
  logic act_take, pre_take, rrd_clear;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_v[b] = act_take && (bank == BA_W'(b));
    assign pre_v[b] = pre_take && (bank == BA_W'(b));
    ddr_bank_slot #(.ROW_W(ROW_W), .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .act_take (act_v[b]),
      .pre_take (pre_v[b]),
      .row_in   (row),
      .is_open  (bank_open[b]),
      .open_row (open_rows[b*ROW_W +: ROW_W]),
      .rcd_done (rcd_done_v[b]),
      .rc_done  (rc_done_v[b])
    );
  end

  ddr_rrd_gate #(.BA_W(BA_W), .RRD_CYC(RRD_CYC)) u_rrd (
    .clk       (clk),
    .rst       (rst),
    .act_take  (act_take),
    .cur_bank  (bank),
    .rrd_clear (rrd_clear)
  );

  ddr_cmd_judge u_judge (
    .cmd          (cmd),
    .sel_open     (bank_open[bank]),
    .sel_rcd_done (rcd_done_v[bank]),
    .sel_rc_done  (rc_done_v[bank]),
    .rrd_clear    (rrd_clear),
    .viol         (viol),
    .legal        (cmd_ok),
    .act_take     (act_take),
    .pre_take     (pre_take)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_q | viol;
  end

  assign err_no_row   = err_q[0];
  assign err_row_open = err_q[1];
  assign err_rcd      = err_q[2];
  assign err_rc       = err_q[3];
  assign err_rrd      = err_q[4];

  // R11: each flag stays set until reset
  for (genvar i = 0; i < 5; i++) begin : g_sticky
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      err_q[i] |=> err_q[i]);
  end
  // R8: a rejected command leaves the open vector unchanged
  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd_ok |=> $stable(bank_open));
  // R2: an accepted access targets an open bank
  p_rw_open_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && ((cmd == CMD_RD) || (cmd == CMD_WR))) |-> bank_open[bank]);

endmodule

// File: tb/tb_ddr_act_checker.sv
module tb_ddr_act_checker;
  localparam int CLK_PERIOD = 10;
  // Independent ceiling in picoseconds: (a + b - 1) / b
  localparam int TCK_PS = 7500;
  localparam int RCD = (20000 + TCK_PS - 1) / TCK_PS;
  localparam int RC  = (65000 + TCK_PS - 1) / TCK_PS;
  localparam int RRD = (15000 + TCK_PS - 1) / TCK_PS;

  logic clk = 0, rst = 1;
  logic [2:0] cmd = 0;
  logic [1:0] bank = 0;
  logic [12:0] row = 0;
  logic cmd_ok, err_no_row, err_row_open, err_rcd, err_rc, err_rrd;
  logic [3:0] bank_open;
  logic [51:0] open_rows;
  int n_chk = 0, n_fail = 0;
  logic last_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_act_checker dut (.clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .row(row),
    .cmd_ok(cmd_ok), .err_no_row(err_no_row), .err_row_open(err_row_open),
    .err_rcd(err_rcd), .err_rc(err_rc), .err_rrd(err_rrd),
    .bank_open(bank_open), .open_rows(open_rows));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r);
    @(negedge clk);
    cmd = c; bank = b; row = r;
    #1 last_ok = cmd_ok;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(3'd0, 2'd0, 13'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; cmd = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 0;
  endtask

  function automatic logic [12:0] row_of(int b);
    return open_rows[b*13 +: 13];
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 bank_open after reset", bank_open, 0);
    check("R1 flags after reset", {err_no_row, err_row_open, err_rcd, err_rc, err_rrd}, 0);
    issue(3'd1, 2'd2, 13'h0AA);
    check("R1 first ACTIVE accepted", last_ok, 1);
    check("R9 bank_open after ACTIVE", bank_open, 4'b0100);
    check("R9 stored row", row_of(2), 13'h0AA);
  endtask

  task automatic t_no_row();
    do_reset();
    issue(3'd2, 2'd0, 0);
    check("R2 READ closed bank rejected", last_ok, 0);
    check("R2 err_no_row set", err_no_row, 1);
    issue(3'd3, 2'd2, 0);
    check("R2 WRITE closed bank rejected", last_ok, 0);
    check("R2 no other flag", {err_row_open, err_rcd, err_rc, err_rrd}, 0);
  endtask

  task automatic t_rcd();
    do_reset();
    issue(3'd1, 2'd1, 13'h155);
    for (int k = 1; k <= RCD; k++) begin
      issue(3'd2, 2'd1, 0);
      check($sformatf("R3 READ at k=%0d", k), last_ok, (k >= RCD) ? 1 : 0);
    end
    check("R3 err_rcd set", err_rcd, 1);
    check("R8 rejected READ kept bank open", bank_open, 4'b0010);
    issue(3'd3, 2'd1, 0);
    check("R3 WRITE after delay", last_ok, 1);
  endtask

  task automatic t_row_open();
    do_reset();
    issue(3'd1, 2'd0, 13'h1234);
    idle(RC);
    issue(3'd1, 2'd0, 13'h0F0F);
    check("R4 ACTIVE to open bank rejected", last_ok, 0);
    check("R4 err_row_open set", err_row_open, 1);
    check("R4 no err_rc", err_rc, 0);
    check("R8 row unchanged", row_of(0), 13'h1234);
  endtask

  task automatic t_rc();
    do_reset();
    issue(3'd1, 2'd3, 13'h0011);  // cycle 0
    idle(2);                       // cycles 1,2
    issue(3'd4, 2'd3, 0);          // cycle 3
    check("R7 PRECHARGE legal", last_ok, 1);
    check("R7 bank closed", bank_open, 0);
    idle(RC - 5);                  // cycles 4..RC-2
    issue(3'd1, 2'd3, 13'h0022);   // cycle RC-1
    check("R5 ACTIVE at RC-1 rejected", last_ok, 0);
    check("R5 err_rc set", err_rc, 1);
    check("R8 rejected ACTIVE left bank closed", bank_open, 0);
    issue(3'd1, 2'd3, 13'h0033);   // cycle RC
    check("R5 ACTIVE at RC accepted", last_ok, 1);
    check("R9 new row stored", row_of(3), 13'h0033);
    check("R5 no err_row_open", err_row_open, 0);
  endtask

  task automatic t_rrd();
    do_reset();
    issue(3'd1, 2'd0, 13'h0001);
    if (RRD > 1) begin
      issue(3'd1, 2'd1, 13'h0002);
      check("R6 other bank too soon rejected", last_ok, 0);
      check("R6 err_rrd set", err_rrd, 1);
    end
    issue(3'd1, 2'd1, 13'h0003);
    check("R10 other bank at exact tRRD accepted", last_ok, 1);
    check("R6 both banks open", bank_open, 4'b0011);
    issue(3'd3, 2'd0, 0);
    check("R6 first bank still accessible", last_ok, 1);
  endtask

  task automatic t_pre_sticky();
    do_reset();
    issue(3'd4, 2'd1, 0);
    check("R7 PRECHARGE closed bank legal", last_ok, 1);
    check("R7 closed bank stays closed", bank_open, 0);
    issue(3'd2, 2'd1, 0);
    idle(4);
    check("R11 err_no_row sticky", err_no_row, 1);
    issue(3'd5, 2'd2, 13'h1FFF);
    check("R11 code 5 legal", last_ok, 1);
    issue(3'd7, 2'd3, 13'h1FFF);
    check("R11 code 7 no effect", bank_open, 0);
    do_reset();
    check("R11 reset clears flags", err_no_row, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_no_row();
    t_rcd();
    t_row_open();
    t_rc();
    t_rrd();
    t_pre_sticky();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule